// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block raises an open-drain interrupt line when any of its fault inputs is high at a monitoring-cycle strobe. It then answers the SMBus alert response address so that the host can find out which device is calling for attention. When the host issues a read to the 7-bit address 0001100 while the interrupt is active, the block acknowledges and shifts out its own device address, most significant bit first. It watches the shared data line as it does so.

Several devices may answer the same address at once. Each one compares the bits it sends with the level it samples on SDA. A device that sends a 1 and sees a 0 has lost: it lets go of SDA for the rest of the byte and keeps its interrupt active. Because a zero always beats a one on the wired-AND bus, the lowest address wins. Only the winner drops its interrupt. If its fault is still present, the interrupt comes back at the next monitoring strobe.

SCL and SDA arrive as inputs that have already been synchronised to the clock. The block pulls SDA low through the output `sda_pull`. It pulls the ALERT line low through the output `alert_pull`.

Top module: `alert_resp_top`

## Requirements
- R1: After reset, `sda_pull` and `alert_pull` are both 0, so neither line is pulled.
- R2: `alert_pull` becomes 1 on the clock edge that samples `mon_strobe` high while any bit of `fault_in` is high. A fault without a strobe does not change `alert_pull`, and neither does a strobe with all faults low.
- R3: The block pulls SDA low during the acknowledge bit in this case: the address byte received after a START is 0x19 (address 0001100 in bits 7..1, read bit 1 in bit 0), and `alert_pull` is 1 when the eighth bit is sampled.
- R4: After its acknowledge, the block sends the byte {DEV_ADDR, 1'b1}, MSB first. Each bit is changed only while SCL is low. With the default DEV_ADDR 0x2C this byte is 0x59.
- R5: If all eight bits are sent without a mismatch, `alert_pull` returns to 0 on the clock edge that samples the rise of SCL for bit 0 of the sent byte.
- R6: The block does not acknowledge, and `alert_pull` keeps its value, in three cases: the alert is inactive, the address byte is not 0x19 (another address, or 0x18 with the write bit), or the frame is not addressed to it.
- R7: Once the alert is cleared by a won response, a later strobe with a fault still high sets `alert_pull` to 1 again.
- R8: A bit counts as lost when the block sends a 1 and samples SDA at 0 on the rise of SCL. On a lost bit the block releases SDA for the rest of the byte and keeps `alert_pull` at 1. When two responders share the bus, the host reads the byte of the lower address.
- R9: A strobe with a fault high may fall on the same clock edge as the win of R5. In that case setting takes priority, and `alert_pull` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| fault_in | input | NUM_FAULTS | Fault flags; any high bit requests an alert |
| mon_strobe | input | 1 | One-clock pulse that marks a monitoring cycle |
| sda_pull | output | 1 | 1 = pull SDA low |
| alert_pull | output | 1 | 1 = pull the active-low ALERT line low |

## Verification
Two events can land on the same clock edge: the win-clear at the rise of SCL for the last sent bit, and a monitoring strobe. The bench sets up this collision by raising SCL for bit 0 and pulsing `mon_strobe` on the same falling clock edge. With a fault held high, the bench expects the alert to survive. With all faults low, it expects the alert to clear. A second competing responder is also modelled in the bench, once with a lower address and once with a higher one. These two cases show which byte the host reads and whose alert drops.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;

  // Responder protocol states
  typedef enum logic [2:0] {
    ST_IDLE,   // no frame in progress
    ST_ADDR,   // shifting in the address byte
    ST_ACKW,   // address matched, waiting for SCL low to drive ACK
    ST_ACK,    // holding ACK low through the ninth clock
    ST_TX,     // sending the response byte with arbitration
    ST_DONE,   // byte sent and won, release on next SCL low
    ST_SKIP    // ignore the bus until START or STOP
  } rsp_state_e;

  // Bus events decoded from the sampled lines
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/smb_bus_cond.sv
module smb_bus_cond
  import alert_resp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_in,
  input  logic    sda_in,
  output bus_ev_t ev
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_in;
    sda_d = sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    ev.scl_rise = scl_in & ~scl_q;
    ev.scl_fall = ~scl_in & scl_q;
    ev.start    = scl_in & scl_q & sda_q & ~sda_in;
    ev.stop     = scl_in & scl_q & ~sda_q & sda_in;
    ev.sda      = sda_in;
  end

endmodule

// File: rtl/smb_alert_flag.sv
module smb_alert_flag #(
  parameter int NUM_FAULTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic                  mon_strobe,
  input  logic                  clr,
  output logic                  alert_q
);

  logic any_fault;
  logic set_en;
  logic alert_d;

  always_comb begin
    any_fault = |fault_in;
    set_en    = mon_strobe & any_fault;
    alert_d   = alert_q;
    if (clr)
      alert_d = 1'b0;
    // a fresh fault seen at a strobe wins over a same-cycle clear
    if (set_en)
      alert_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alert_q <= 1'b0;
    else if (set_en | clr)
      alert_q <= alert_d;
  end

endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import alert_resp_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bus_ev_t    ev,
  input  logic       alert_act,
  output logic       sda_pull,
  output logic       win,
  output rsp_state_e state,
  output logic       tx_msb
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_RD   = {ARA_ADDR, 1'b1};
  localparam logic [BYTE_W-1:0] RESP     = {DEV_ADDR, 1'b1};

  rsp_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              drv_q, drv_d;
  logic [BYTE_W-1:0] rx_byte;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    drv_d   = drv_q;
    win     = 1'b0;
    rx_byte = {sh_q[BYTE_W-2:0], ev.sda};
    if (ev.stop) begin
      state_d = ST_IDLE;
      drv_d   = 1'b0;
    end else if (ev.start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (ev.scl_rise) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (rx_byte == ARA_RD && alert_act)
                state_d = ST_ACKW;
              else
                state_d = ST_SKIP;
            end
          end
        end
        ST_ACKW: begin
          if (ev.scl_fall) begin
            drv_d   = 1'b1;
            state_d = ST_ACK;
          end
        end
        ST_ACK: begin
          if (ev.scl_fall) begin
            state_d = ST_TX;
            cnt_d   = '0;
            sh_d    = RESP;
            drv_d   = ~RESP[BYTE_W-1];
          end
        end
        ST_TX: begin
          if (ev.scl_rise) begin
            if (sh_q[BYTE_W-1] && !ev.sda) begin
              state_d = ST_SKIP;
              drv_d   = 1'b0;
            end else if (cnt_q == LAST_BIT) begin
              win     = 1'b1;
              state_d = ST_DONE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (ev.scl_fall) begin
            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
            drv_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_DONE: begin
          if (ev.scl_fall) begin
            drv_d   = 1'b0;
            state_d = ST_SKIP;
          end
        end
        ST_SKIP: ;
        default: begin
          state_d = ST_IDLE;
          drv_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      drv_q   <= drv_d;
    end
  end

  assign sda_pull = drv_q;
  assign state    = state_q;
  assign tx_msb   = sh_q[BYTE_W-1];

endmodule

// File: rtl/alert_resp_top.sv
module alert_resp_top
  import alert_resp_pkg::*;
#(
  parameter int                NUM_FAULTS = 4,
  parameter int                ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR   = 7'h2C,
  parameter logic [ADDR_W-1:0] ARA_ADDR   = 7'b0001100,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic                  mon_strobe,
  output logic                  sda_pull,
  output logic                  alert_pull
);

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_chain <= '0;
    else
      rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rst_chain[SYNC_STAGES-1];

  bus_ev_t    ev;
  logic       win_pulse;
  logic       alert_q;
  rsp_state_e fsm_state;
  logic       tx_msb;

  smb_bus_cond u_cond (
    .clk    (clk),
    .rst_n  (rst_ns),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  smb_alert_flag #(
    .NUM_FAULTS (NUM_FAULTS)
  ) u_flag (
    .clk        (clk),
    .rst_n      (rst_ns),
    .fault_in   (fault_in),
    .mon_strobe (mon_strobe),
    .clr        (win_pulse),
    .alert_q    (alert_q)
  );

  smb_ara_fsm #(
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR),
    .ARA_ADDR (ARA_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .ev        (ev),
    .alert_act (alert_q),
    .sda_pull  (sda_pull),
    .win       (win_pulse),
    .state     (fsm_state),
    .tx_msb    (tx_msb)
  );

  assign alert_pull = alert_q;

endmodule

// File: rtl/alert_resp_chk.sv
module alert_resp_chk
  import alert_resp_pkg::*;
#(
  parameter int NUM_FAULTS = 4
) (
  input logic                  clk,
  input logic                  rst_ns,
  input logic [NUM_FAULTS-1:0] fault_in,
  input logic                  mon_strobe,
  input logic                  sda_pull,
  input logic                  alert_pull,
  input logic                  win_pulse,
  input rsp_state_e            fsm_state,
  input logic                  tx_msb,
  input bus_ev_t               ev
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (fsm_state == ST_IDLE) |-> !sda_pull);

  // R2
  alert_set_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mon_strobe && (|fault_in)) |=> alert_pull);

  // R2
  alert_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(alert_pull) |-> $past(mon_strobe && (|fault_in)));

  // R5
  alert_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(alert_pull) |-> $past(win_pulse));

  // R3
  ack_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(sda_pull) && fsm_state == ST_ACK) |-> alert_pull);

  // R8
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (fsm_state == ST_TX && ev.scl_rise && tx_msb && !ev.sda) |=> (!sda_pull && fsm_state == ST_SKIP));

  // R9
  set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (win_pulse && mon_strobe && (|fault_in)) |=> alert_pull);

endmodule

bind alert_resp_top alert_resp_chk #(.NUM_FAULTS(NUM_FAULTS)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .fault_in   (fault_in),
  .mon_strobe (mon_strobe),
  .sda_pull   (sda_pull),
  .alert_pull (alert_pull),
  .win_pulse  (win_pulse),
  .fsm_state  (fsm_state),
  .tx_msb     (tx_msb),
  .ev         (ev)
);

// File: tb/alert_resp_top_test.sv
module alert_resp_top_test;

  localparam int   NF   = 4;
  localparam logic [6:0] OWN = 7'h2C;
  localparam logic [6:0] ARA = 7'b0001100;
  localparam int   H    = 6;

  logic clk, rst_n;
  logic scl_m, sda_m, comp_pull;
  logic [NF-1:0] fault_in;
  logic mon_strobe;
  logic sda_pull, alert_pull;
  wire  sda_line = sda_m & ~sda_pull & ~comp_pull;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // competitor responder model
  logic       comp_en;
  logic [6:0] comp_addr;

  typedef struct {
    logic       ack;
    logic [7:0] data;
    logic       alert;
    string      req;
  } txn_t;

  txn_t exp_q[$];
  txn_t obs_q[$];
  event obs_ev;

  alert_resp_top #(.NUM_FAULTS(NF), .DEV_ADDR(OWN)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .fault_in   (fault_in),
    .mon_strobe (mon_strobe),
    .sda_pull   (sda_pull),
    .alert_pull (alert_pull)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic ack, input logic [7:0] data,
                          input logic alert, input string req);
    txn_t t;
    t.ack = ack; t.data = data; t.alert = alert; t.req = req;
    exp_q.push_back(t);
  endtask

  // one SCL period: master drives drv, optional strobe on the rise
  task automatic clock_bit(input logic drv, input logic strobe_hi, output logic seen);
    sda_m = drv;
    wait_clk(H);
    scl_m = 1'b1;
    if (strobe_hi) mon_strobe = 1'b1;
    wait_clk(1);
    mon_strobe = 1'b0;
    wait_clk(H - 1);
    seen = sda_line;
    wait_clk(H);
    scl_m = 1'b0;
    wait_clk(H);
  endtask

  task automatic run_txn(input logic [6:0] a, input logic rw, input logic strobe_last);
    logic [7:0] abyte, rd;
    logic s, ack, comp_on, comp_lost;
    logic [7:0] cbyte;
    txn_t o;
    abyte = {a, rw};
    cbyte = {comp_addr, 1'b1};
    comp_on = comp_en && rw && (a == ARA);
    comp_lost = 1'b0;
    rd = 8'hFF;
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
    for (int i = 7; i >= 0; i--) clock_bit(abyte[i], 1'b0, s);
    comp_pull = comp_on;
    clock_bit(1'b1, 1'b0, s);
    comp_pull = 1'b0;
    ack = !s;
    if (ack) begin
      for (int i = 7; i >= 0; i--) begin
        comp_pull = comp_on && !comp_lost && !cbyte[i];
        clock_bit(1'b1, strobe_last && (i == 0), s);
        rd[i] = s;
        if (comp_on && !comp_lost && cbyte[i] && !s) comp_lost = 1'b1;
      end
      comp_pull = 1'b0;
      clock_bit(1'b1, 1'b0, s);
    end
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
    o.ack = ack; o.data = rd; o.alert = alert_pull; o.req = "";
    obs_q.push_back(o);
    ->obs_ev;
    wait_clk(2);
  endtask

  // monitor: pops expected and observed results and compares them
  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        txn_t e, o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        chk(o.ack == e.ack, e.req, "ack", {7'd0, o.ack}, {7'd0, e.ack});
        chk(o.data == e.data, e.req, "read byte", o.data, e.data);
        chk(o.alert == e.alert, e.req, "alert after frame", {7'd0, o.alert}, {7'd0, e.alert});
      end
    end
  end

  task automatic strobe;
    mon_strobe = 1'b1; wait_clk(1); mon_strobe = 1'b0; wait_clk(1);
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; comp_pull = 1'b0;
    fault_in = '0; mon_strobe = 1'b0; comp_en = 1'b0; comp_addr = 7'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk(sda_pull == 1'b0, "R1", "sda_pull after reset", {7'd0, sda_pull}, 8'd0);
    chk(alert_pull == 1'b0, "R1", "alert_pull after reset", {7'd0, alert_pull}, 8'd0);

    // R2 fault without strobe, strobe without fault
    fault_in = 4'b0010; wait_clk(5);
    chk(alert_pull == 1'b0, "R2", "fault without strobe", {7'd0, alert_pull}, 8'd0);
    fault_in = '0; strobe();
    chk(alert_pull == 1'b0, "R2", "strobe without fault", {7'd0, alert_pull}, 8'd0);

    // R6 no alert: ARA read is not acknowledged
    push_exp(1'b0, 8'hFF, 1'b0, "R6"); run_txn(ARA, 1'b1, 1'b0);

    // R2 set on strobe with a fault
    fault_in = 4'b0100; strobe();
    chk(alert_pull == 1'b1, "R2", "strobe with fault", {7'd0, alert_pull}, 8'd1);
    fault_in = '0; strobe();
    chk(alert_pull == 1'b1, "R2", "strobe with no fault keeps alert", {7'd0, alert_pull}, 8'd1);

    // R6 other address, and write to ARA
    push_exp(1'b0, 8'hFF, 1'b1, "R6"); run_txn(OWN, 1'b1, 1'b0);
    push_exp(1'b0, 8'hFF, 1'b1, "R6"); run_txn(ARA, 1'b0, 1'b0);

    // R3 R4 R5 alert response read, win clears alert
    push_exp(1'b1, 8'h59, 1'b0, "R3_R4_R5"); run_txn(ARA, 1'b1, 1'b0);

    // R7 re-raise while fault persists
    fault_in = 4'b0001; strobe();
    chk(alert_pull == 1'b1, "R7", "alert set", {7'd0, alert_pull}, 8'd1);
    push_exp(1'b1, 8'h59, 1'b0, "R7"); run_txn(ARA, 1'b1, 1'b0);
    strobe();
    chk(alert_pull == 1'b1, "R7", "alert re-raised at next strobe", {7'd0, alert_pull}, 8'd1);

    // R8 competitor with lower address wins, alert kept
    comp_en = 1'b1; comp_addr = 7'h15;
    push_exp(1'b1, 8'h2B, 1'b1, "R8"); run_txn(ARA, 1'b1, 1'b0);
    // R8 competitor with higher address loses, alert cleared
    fault_in = '0;
    comp_addr = 7'h4D;
    push_exp(1'b1, 8'h59, 1'b0, "R8"); run_txn(ARA, 1'b1, 1'b0);
    comp_en = 1'b0;

    // R9 strobe on the win edge: set wins while the fault is present
    fault_in = 4'b1000; strobe();
    push_exp(1'b1, 8'h59, 1'b1, "R9"); run_txn(ARA, 1'b1, 1'b1);
    // R9 same edge with no fault: clear takes effect
    fault_in = '0;
    push_exp(1'b1, 8'h59, 1'b0, "R9"); run_txn(ARA, 1'b1, 1'b1);

    wait_clk(4);
    chk(exp_q.size() == 0, "R4", "unmatched expected items", 8'(exp_q.size()), 8'd0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule